// File: doc/BRIEF.md
# Next Instruction Address Unit

This block works out where a 32-bit processor fetches next. Each input beat carries the current program counter, the instruction word fetched from that address, and the two register operands read for that instruction. The block returns one output beat. That beat holds the next program counter, a flag that says whether the sequential path was left, and a request to write the return address into the link register when the instruction is a jump-and-link.

The block supports five kinds of control flow:
- Sequential fall-through.
- Two conditional branches: one taken on equal operands, one on unequal operands. Both are PC-relative and use a signed word offset.
- A direct jump and a direct jump-and-link. Both keep the upper bits of the incremented PC and take the rest of the address from the 26-bit instruction field.
- A jump to an address held in a register.

Both stream edges use valid/ready. An input beat is accepted on a clock edge where `in_valid` and `in_ready` are both high. The unit holds one result at a time. `in_ready` is high when the output register is empty or when its result is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat stays frozen and no new input is accepted. Each result appears one cycle after its input is accepted.

Top module: `npc_unit`

## Requirements
- R1: An instruction that is not one of the control transfers listed below gives a next PC of `in_pc + 4`, with `out_redirect` and `out_link_we` low. This covers all non-zero opcodes other than 2, 3, 4 and 5, and all opcode 0 words whose funct (bits 5..0) is not 8.
- R2: An instruction with opcode (bits 31..26) equal to 4 branches when `in_rs_val == in_rt_val`. The target is `in_pc + 4 + (offset << 2)`, where the offset is bits 15..0. When the operands differ, the next PC is `in_pc + 4`.
- R3: An instruction with opcode 5 branches when the two operands differ and falls through to `in_pc + 4` when they are equal. It uses the same target arithmetic as R2; for example, PC 80016 with offset 2 gives 80028.
- R4: The 16-bit branch offset is sign-extended before scaling. An offset with bit 15 set therefore branches backward, and 0x8000 moves the target down by 131072 bytes from `in_pc + 4`.
- R5: Opcode 2 jumps to an address built from three parts, from high bits to low: bits 31..28 of `in_pc + 4`, then instruction bits 25..0, then two zero bits. The upper bits come from the incremented PC, so they change when `in_pc + 4` crosses a 256 MiB boundary.
- R6: Opcode 3 jumps exactly as R5 does. It also raises `out_link_we` with `out_link_reg = 31` and `out_link_addr = in_pc + 4`.
- R7: An opcode 0 word with funct 8 sets the next PC to `in_rs_val` and does not request a link write. Funct 9 under opcode 0 is not a control transfer and is handled under R1.
- R8: An input beat is accepted when `in_valid && in_ready`, and `in_ready` is high exactly when `!out_valid || out_ready`. Each accepted beat produces exactly one output beat one cycle later, and beats leave in the order they arrived. While `out_valid && !out_ready`, every output field holds its value.
- R9: During reset and after its release, `out_valid` is low and `in_ready` is high until the first input beat is accepted.
- R10: `out_redirect` is high exactly when the next PC comes from a taken branch or from one of the jumps (R2 to R7). `out_link_we` is high only for opcode 3, and `out_link_reg` and `out_link_addr` are zero when `out_link_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take an input beat this cycle |
| in_pc | input | 32 | Address of the instruction |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of the first source register |
| in_rt_val | input | 32 | Value of the second source register |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 32 | Address to fetch next |
| out_redirect | output | 1 | Next PC departs from the sequential path |
| out_link_we | output | 1 | Request to write the return address |
| out_link_reg | output | 5 | Register index for the link write |
| out_link_addr | output | 32 | Return address to write |

## Verification
Two functions can land in the same cycle: a jump-and-link raises the redirect and the link write in one beat, and back-pressure on the output can coincide with a new input beat being offered. The bench sends a jump-and-link while the consumer is deasserting `out_ready` on a repeating pattern. It then checks that the redirect target and the return address arrive together in a single beat, and that the beat holds unchanged through every stalled cycle. It also checks that the waiting input is taken only after the consumer releases the stall, with no beat lost or duplicated.

// File: rtl/npc_pkg.sv
package npc_pkg;

  localparam int unsigned OPC_W   = 6;
  localparam int unsigned FUNCT_W = 6;

  localparam logic [OPC_W-1:0]   OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0]   OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0]   OPC_JLINK   = 6'd3;
  localparam logic [OPC_W-1:0]   OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0]   OPC_BRNE    = 6'd5;
  localparam logic [FUNCT_W-1:0] FN_REGJUMP  = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ   = 3'd0,
    FLOW_BREQ  = 3'd1,
    FLOW_BRNE  = 3'd2,
    FLOW_JUMP  = 3'd3,
    FLOW_JLINK = 3'd4,
    FLOW_REG   = 3'd5
  } flow_e;

endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
#(
  parameter int unsigned INSTR_W = 32,
  parameter int unsigned OFF_W   = 16,
  parameter int unsigned TGT_W   = 26
) (
  input  logic [INSTR_W-1:0] instr,
  output flow_e              flow,
  output logic [OFF_W-1:0]   offset,
  output logic [TGT_W-1:0]   target
);

  logic [OPC_W-1:0]   opc;
  logic [FUNCT_W-1:0] fn;

  assign opc    = instr[INSTR_W-1 -: OPC_W];
  assign fn     = instr[FUNCT_W-1:0];
  assign offset = instr[OFF_W-1:0];
  assign target = instr[TGT_W-1:0];

  always_comb begin
    flow = FLOW_SEQ;
    unique case (opc)
      OPC_SPECIAL: if (fn == FN_REGJUMP) flow = FLOW_REG;
      OPC_JUMP:    flow = FLOW_JUMP;
      OPC_JLINK:   flow = FLOW_JLINK;
      OPC_BREQ:    flow = FLOW_BREQ;
      OPC_BRNE:    flow = FLOW_BRNE;
      default:     flow = FLOW_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned TGT_W  = 26,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned LINK_R = 31
) (
  input  logic [PC_W-1:0]  pc,
  input  flow_e            flow,
  input  logic [OFF_W-1:0] offset,
  input  logic [TGT_W-1:0] target,
  input  logic [PC_W-1:0]  rs_val,
  input  logic [PC_W-1:0]  rt_val,
  output logic [PC_W-1:0]  next_pc,
  output logic             redirect,
  output logic             link_we,
  output logic [REG_W-1:0] link_reg,
  output logic [PC_W-1:0]  link_addr
);

  localparam int unsigned EXT_W  = PC_W - OFF_W - 2;
  localparam int unsigned HIGH_W = PC_W - TGT_W - 2;

  logic [PC_W-1:0] pc_inc;
  logic [PC_W-1:0] br_disp;
  logic [PC_W-1:0] br_dest;
  logic [PC_W-1:0] jmp_dest;
  logic            same;
  logic            br_take;

  assign pc_inc   = pc + PC_W'(4);
  assign br_disp  = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign br_dest  = pc_inc + br_disp;
  assign jmp_dest = {pc_inc[PC_W-1 -: HIGH_W], target, 2'b00};
  assign same     = (rs_val == rt_val);
  assign br_take  = ((flow == FLOW_BREQ) && same) || ((flow == FLOW_BRNE) && !same);

  always_comb begin
    next_pc  = pc_inc;
    redirect = 1'b0;
    unique case (flow)
      FLOW_BREQ, FLOW_BRNE: begin
        if (br_take) begin
          next_pc  = br_dest;
          redirect = 1'b1;
        end
      end
      FLOW_JUMP, FLOW_JLINK: begin
        next_pc  = jmp_dest;
        redirect = 1'b1;
      end
      FLOW_REG: begin
        next_pc  = rs_val;
        redirect = 1'b1;
      end
      default: begin
        next_pc  = pc_inc;
        redirect = 1'b0;
      end
    endcase
  end

  assign link_we   = (flow == FLOW_JLINK);
  assign link_reg  = link_we ? REG_W'(LINK_R) : '0;
  assign link_addr = link_we ? pc_inc : '0;

endmodule

// File: rtl/npc_stage.sv
module npc_stage #(
  parameter int unsigned DATA_W = 70
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready  = !full_q || out_ready;
  assign take      = in_valid && in_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (take) begin
        full_q <= 1'b1;
        data_q <= in_data;
      end else if (out_ready) begin
        full_q <= 1'b0;
      end
    end
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));

  p_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned PC_W   = 32,
  parameter int unsigned OFF_W  = 16,
  parameter int unsigned TGT_W  = 26,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned LINK_R = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PC_W-1:0]  in_pc,
  input  logic [PC_W-1:0]  in_instr,
  input  logic [PC_W-1:0]  in_rs_val,
  input  logic [PC_W-1:0]  in_rt_val,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PC_W-1:0]  out_next_pc,
  output logic             out_redirect,
  output logic             out_link_we,
  output logic [REG_W-1:0] out_link_reg,
  output logic [PC_W-1:0]  out_link_addr
);

  localparam int unsigned BEAT_W = 2 * PC_W + REG_W + 2;

  flow_e             flow;
  logic [OFF_W-1:0]  offset;
  logic [TGT_W-1:0]  target;
  logic [PC_W-1:0]   nx_pc;
  logic              nx_redir;
  logic              nx_lwe;
  logic [REG_W-1:0]  nx_lreg;
  logic [PC_W-1:0]   nx_laddr;
  logic [BEAT_W-1:0] beat_in;
  logic [BEAT_W-1:0] beat_out;

  npc_decode #(.INSTR_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_dec (
    .instr  (in_instr),
    .flow   (flow),
    .offset (offset),
    .target (target)
  );

  npc_target #(
    .PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W), .REG_W(REG_W), .LINK_R(LINK_R)
  ) u_tgt (
    .pc        (in_pc),
    .flow      (flow),
    .offset    (offset),
    .target    (target),
    .rs_val    (in_rs_val),
    .rt_val    (in_rt_val),
    .next_pc   (nx_pc),
    .redirect  (nx_redir),
    .link_we   (nx_lwe),
    .link_reg  (nx_lreg),
    .link_addr (nx_laddr)
  );

  assign beat_in = {nx_pc, nx_redir, nx_lwe, nx_lreg, nx_laddr};

  npc_stage #(.DATA_W(BEAT_W)) u_stg (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (beat_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (beat_out)
  );

  assign {out_next_pc, out_redirect, out_link_we, out_link_reg, out_link_addr} = beat_out;

  p_seq_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[31:26] == 6'd35)
      |=> (out_next_pc == $past(in_pc) + 32'd4 && !out_redirect && !out_link_we));

  p_jal_link_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[31:26] == 6'd3)
      |=> (out_link_we && out_link_reg == 5'd31 && out_link_addr == $past(in_pc) + 32'd4));

  p_regjump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_instr[31:26] == 6'd0 && in_instr[5:0] == 6'd8)
      |=> (out_next_pc == $past(in_rs_val) && !out_link_we));

  p_link_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_link_we) |-> (out_link_reg == '0 && out_link_addr == '0));

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

endmodule

// File: tb/npc_unit_test.sv
module npc_unit_test;

  typedef struct packed {
    logic [31:0] npc;
    logic        redir;
    logic        lwe;
    logic [4:0]  lreg;
    logic [31:0] laddr;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0, in_instr = '0, in_rs_val = '0, in_rt_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_next_pc;
  logic        out_redirect;
  logic        out_link_we;
  logic [4:0]  out_link_reg;
  logic [31:0] out_link_addr;

  exp_t        sb[$];
  int          n_checks = 0;
  int          n_fail = 0;
  bit          drv_done = 1'b0;
  int          stall_pat = 0;

  always #10 clk = ~clk;

  npc_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_instr(in_instr), .in_rs_val(in_rs_val), .in_rt_val(in_rt_val),
    .out_valid(out_valid), .out_ready(out_ready), .out_next_pc(out_next_pc),
    .out_redirect(out_redirect), .out_link_we(out_link_we),
    .out_link_reg(out_link_reg), .out_link_addr(out_link_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected result derived from the requirements
  function automatic exp_t model(input logic [31:0] pc, input logic [31:0] ins,
                                 input logic [31:0] rs, input logic [31:0] rt);
    exp_t e;
    logic [31:0] p4;
    logic [31:0] off;
    p4 = pc + 32'd4;
    off = {{14{ins[15]}}, ins[15:0], 2'b00};
    e = '{npc: p4, redir: 1'b0, lwe: 1'b0, lreg: 5'd0, laddr: 32'd0};
    if (ins[31:26] == 6'd4 && rs == rt) begin e.npc = p4 + off; e.redir = 1'b1; end
    else if (ins[31:26] == 6'd5 && rs != rt) begin e.npc = p4 + off; e.redir = 1'b1; end
    else if (ins[31:26] == 6'd2 || ins[31:26] == 6'd3) begin
      e.npc = {p4[31:28], ins[25:0], 2'b00};
      e.redir = 1'b1;
      if (ins[31:26] == 6'd3) begin e.lwe = 1'b1; e.lreg = 5'd31; e.laddr = p4; end
    end else if (ins[31:26] == 6'd0 && ins[5:0] == 6'd8) begin
      e.npc = rs; e.redir = 1'b1;
    end
    return e;
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic send(input logic [31:0] pc, input logic [31:0] ins,
                      input logic [31:0] rs, input logic [31:0] rt);
    in_valid = 1'b1; in_pc = pc; in_instr = ins; in_rs_val = rs; in_rt_val = rt;
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    sb.push_back(model(pc, ins, rs, rt));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // monitor: set consumer readiness, compare popped items, watch stalls (R8)
  initial begin : monitor
    exp_t e;
    bit stalled;
    logic [31:0] s_npc, s_laddr;
    logic s_red, s_lwe;
    stalled = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        stall_pat++;
        out_ready = (stall_pat % 5 != 2) && (stall_pat % 7 != 3);
      end
      #1;
      if (stalled && out_valid) begin
        check(out_next_pc == s_npc && out_redirect == s_red &&
              out_link_we == s_lwe && out_link_addr == s_laddr,
              "R8 hold", out_next_pc, s_npc);
      end
      stalled = 1'b0;
      if (out_valid && !out_ready) begin
        stalled = 1'b1;
        s_npc = out_next_pc; s_red = out_redirect;
        s_lwe = out_link_we; s_laddr = out_link_addr;
      end
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          check(1'b0, "R8 extra beat", out_next_pc, 32'h0);
        end else begin
          e = sb.pop_front();
          check(out_next_pc == e.npc, "R1-R7 next pc", out_next_pc, e.npc);
          check(out_redirect == e.redir, "R10 redirect", {31'd0, out_redirect}, {31'd0, e.redir});
          check(out_link_we == e.lwe && out_link_reg == e.lreg && out_link_addr == e.laddr,
                "R6/R10 link", out_link_addr, e.laddr);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    check(out_valid == 1'b0 && in_ready == 1'b1, "R9 idle after reset",
          {30'd0, out_valid, in_ready}, 32'd1);
    // R1 sequential: add (op 0 funct 32), load (op 35), op 0 funct 9
    send(32'h0000_1000, 32'h0232_4020, 32'd1, 32'd2);
    send(32'h0000_1004, 32'h8E68_0020, 32'd0, 32'd0);
    send(32'h0000_1008, 32'h0200_0009, 32'h5555_0000, 32'd0);
    // R2 beq taken / not taken
    send(32'h0000_0100, {6'd4, 10'd0, 16'd3}, 32'd7, 32'd7);
    send(32'h0000_0100, {6'd4, 10'd0, 16'd3}, 32'd7, 32'd8);
    // R3 bne worked case 80016 -> 80028, and equal operands fall through
    send(32'd80016, {6'd5, 5'd8, 5'd21, 16'd2}, 32'd1, 32'd2);
    send(32'd80016, {6'd5, 5'd8, 5'd21, 16'd2}, 32'd9, 32'd9);
    // R4 backward and most negative offsets
    send(32'h0000_0200, {6'd4, 10'd0, 16'hFFFC}, 32'd0, 32'd0);
    send(32'h0010_0000, {6'd5, 10'd0, 16'h8000}, 32'd0, 32'd1);
    // R5 jump, including crossing into the next 256 MiB region
    send(32'hA000_0010, {6'd2, 26'h000_0100}, 32'd0, 32'd0);
    send(32'hAFFF_FFFC, {6'd2, 26'h000_0040}, 32'd0, 32'd0);
    // R6 jump-and-link, back to back to coincide with stalls
    send(32'h0040_0020, {6'd3, 26'h010_0000}, 32'd0, 32'd0);
    send(32'h0040_0024, {6'd3, 26'h3FF_FFFF}, 32'd0, 32'd0);
    // R7 register jump
    send(32'h0000_3000, {6'd0, 5'd31, 15'd0, 6'd8}, 32'h1234_5678, 32'd3);
    send(32'h0000_3004, {6'd0, 5'd4, 15'd0, 6'd8}, 32'h0040_0028, 32'h0040_0028);
    // a burst of mixed items through repeated stalls (R8 ordering)
    for (int i = 0; i < 16; i++) begin
      send(32'h0000_8000 + 32'(i * 4), {6'd5, 10'd0, 16'(i)}, 32'(i), 32'(i & 3));
    end
    repeat (20) @(negedge clk);
    check(sb.size() == 0, "R8 all beats delivered", 32'(sb.size()), 32'd0);
    drv_done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule